// File: doc/BRIEF.md
# Register Write-Protection Unlock Gate

This block sits beside a register file and decides, on each write strobe, whether the addressed register may take the data. Ordinary register groups are guarded by lock bits that live in a small lock register. A few sensitive locations are kept shut behind two code gates. Each gate opens its window only after a fixed series of bytes has been written to its own gate address, one byte per write. A further write to that gate address closes the window again.

The block keeps the lock bits, the progress of both code sequencers and the open or closed state of both windows. It drives a combinational write-allow bit in the same cycle as the strobe. It also drives two window-status outputs, and a one-cycle pulse that reports that the lock bits have just been restored to their defaults. A program-mode input opens a small configuration range that no lock bit controls. Reads, the serial framing and the register storage itself are handled elsewhere.

Top module: `reg_write_gate`

## Requirements
- R1: Writes to 00h–17h, 20h–37h and 40h–44h are allowed exactly when lock bit 0 (brightness) is 0. This bit resets to 0.
- R2: Writes to 50h–67h are allowed exactly when lock bit 1 (current) is 0. This bit resets to 1.
- R3: Writes to 70h–83h are allowed exactly when lock bit 2 (configuration) is 0. This bit resets to 1.
- R4: Writes to 84h–87h are allowed exactly when `prog_mode` is 1, whatever the lock bits hold.
- R5: `wr_allow` is 1 for writes to 90h, 91h, 96h and 98h. It is 0 for every address that no requirement names, and it is always 0 when `wr_en` is 0.
- R6: After the bytes 43h, 4Fh, 44h, 45h have been written to 96h in that order, `ctrl_open` is 1 from the next cycle. Writes to 92h–95h are allowed exactly while `ctrl_open` is 1.
- R7: While `ctrl_open` is 1, a write of any byte to 96h makes it 0 in the next cycle. That closing write does not count toward a new sequence.
- R8: Every write to 96h returns `lock_state` to 0110b in the next cycle. In that next cycle `lock_reset_pulse` is 1, and it is 1 for that one cycle only.
- R9: An allowed write to 93h loads `wr_data[3:0]` into `lock_state` (bit 0 brightness, bit 1 current, bit 2 configuration, bit 3 stored but guarding nothing). No other write changes `lock_state`, except a write to 96h.
- R10: After the bytes 00h, 04h, 02h, 09h, 02h, 09h have been written to 98h in order, `mem_open` is 1 from the next cycle. Writes to 97h are allowed exactly while `mem_open` is 1. Any later write to 98h makes `mem_open` 0.
- R11: In either sequencer, a gate byte that differs from the expected next byte restarts the sequence. If that byte equals the first code byte, it counts as the first step.
- R12: While `rst_n` is 0 at a clock edge, `lock_state` becomes 0110b, both windows close, `lock_reset_pulse` becomes 0, and any partial code progress is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Target register address |
| wr_data | input | 8 | Write data byte |
| prog_mode | input | 1 | Nonvolatile program state; opens 84h–87h |
| wr_allow | output | 1 | The current write may change its register |
| ctrl_open | output | 1 | Control window 92h–95h is open |
| mem_open | output | 1 | Memory-control window 97h is open |
| lock_state | output | 4 | Current lock bits (register 93h) |
| lock_reset_pulse | output | 1 | One cycle after any write to 96h |

## Verification
The hardest states to reach from the ports are those where a sequencer has made part of its progress and then meets a wrong byte that equals the first code byte. The same holds for the memory code, whose repeated pairs 02h, 09h make a naive restart look correct. The bench drives sequences with a stray 43h in the middle of the control code. It drives a memory code that breaks after five bytes with 00h. It also applies reset after three of the four control bytes. A reference model in the bench tracks the lock bits and both windows across every write. Full 256-address sweeps are run in several lock, window and program-mode states, and every result is compared with that model.

// File: rtl/rwg_pkg.sv
// Package rwg_pkg
// Shared constants, the region type and the address classifier for the
// register write gate. Assumes 8-bit addresses and 8-bit data.
package rwg_pkg;

    localparam int unsigned AW = 8;
    localparam int unsigned DW = 8;
    localparam int unsigned LOCK_W = 4;

    // Lock bit positions
    localparam int unsigned LK_BRT = 0;
    localparam int unsigned LK_CUR = 1;
    localparam int unsigned LK_CFG = 2;

    localparam logic [LOCK_W-1:0] LOCK_DEFAULT = 4'b0110;

    localparam logic [AW-1:0] ADDR_LOCK  = 8'h93;
    localparam logic [AW-1:0] ADDR_CGATE = 8'h96;
    localparam logic [AW-1:0] ADDR_MGATE = 8'h98;

    // Code sequences, first byte in the lowest byte lane
    localparam int unsigned CTRL_LEN = 4;
    localparam logic [CTRL_LEN*DW-1:0] CTRL_CODE = {8'h45, 8'h44, 8'h4F, 8'h43};
    localparam int unsigned MEM_LEN = 6;
    localparam logic [MEM_LEN*DW-1:0] MEM_CODE = {8'h09, 8'h02, 8'h09, 8'h02, 8'h04, 8'h00};

    typedef enum logic [3:0] {
        RG_BRT, RG_CUR, RG_CFG, RG_PROG, RG_FREE,
        RG_CTRL, RG_CGATE, RG_MEM, RG_MGATE, RG_NONE
    } rwg_region_e;

    // Map an address to its protection region
    function automatic rwg_region_e classify(input logic [AW-1:0] a);
        rwg_region_e r;
        if (a <= 8'h17 || (a >= 8'h20 && a <= 8'h37) || (a >= 8'h40 && a <= 8'h44))
            r = RG_BRT;
        else if (a >= 8'h50 && a <= 8'h67)
            r = RG_CUR;
        else if (a >= 8'h70 && a <= 8'h83)
            r = RG_CFG;
        else if (a >= 8'h84 && a <= 8'h87)
            r = RG_PROG;
        else if (a == 8'h90 || a == 8'h91)
            r = RG_FREE;
        else if (a >= 8'h92 && a <= 8'h95)
            r = RG_CTRL;
        else if (a == ADDR_CGATE)
            r = RG_CGATE;
        else if (a == 8'h97)
            r = RG_MEM;
        else if (a == ADDR_MGATE)
            r = RG_MGATE;
        else
            r = RG_NONE;
        return r;
    endfunction

endpackage

// File: rtl/rwg_gate_seq.sv
// Module rwg_gate_seq
// Recognises a byte code written one byte per strobe to a gate address.
// A full match opens the window; any gate write while open closes it.
// A mismatch restarts, and a byte equal to the first code byte counts as step one.
// Assumes CODE_LEN >= 2 and that the first code byte sits in lane 0 of CODE.
module rwg_gate_seq #(
    parameter int unsigned CODE_LEN = 4,
    parameter int unsigned BYTE_W   = 8,
    parameter logic [CODE_LEN*BYTE_W-1:0] CODE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [BYTE_W-1:0] data,
    output logic              open
);
    localparam int unsigned IW = (CODE_LEN > 1) ? $clog2(CODE_LEN) : 1;
    localparam logic [IW-1:0] LAST = IW'(CODE_LEN - 1);
    localparam logic [BYTE_W-1:0] FIRST = CODE[BYTE_W-1:0];

    logic [IW-1:0]     idx_q;
    logic [BYTE_W-1:0] expect_byte;

    // Select the byte the sequence expects next
    always_comb begin
        expect_byte = CODE[idx_q*BYTE_W +: BYTE_W];
    end

    // Advance, restart or toggle the window on each gate write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open  <= 1'b0;
            idx_q <= '0;
        end else if (hit) begin
            if (open) begin
                open  <= 1'b0;
                idx_q <= '0;
            end else if (data == expect_byte) begin
                if (idx_q == LAST) begin
                    open  <= 1'b1;
                    idx_q <= '0;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end else begin
                idx_q <= (data == FIRST) ? IW'(1) : '0;
            end
        end
    end

    // R11: progress never passes the code length
    p_idx_in_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= LAST);

    // R6/R10: window state only moves on a gate write
    p_open_needs_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(open));

    // R7: an open window always closes on the next gate write
    p_gate_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && open) |=> !open);

endmodule

// File: rtl/rwg_lock_reg.sv
// Module rwg_lock_reg
// Holds the lock bits. A load writes new bits; a restore returns them to
// the default and raises a one-cycle pulse in the following cycle.
// Assumes load and restore are never asserted together (different addresses).
module rwg_lock_reg #(
    parameter int unsigned WIDTH = 4,
    parameter logic [WIDTH-1:0] DEFAULT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             restore,
    input  logic [WIDTH-1:0] data,
    output logic [WIDTH-1:0] lock_q,
    output logic             restored
);
    // Update lock bits from a load or restore
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock_q <= DEFAULT;
        else if (restore)
            lock_q <= DEFAULT;
        else if (load)
            lock_q <= data;
    end

    // Register the restore event as a single-cycle pulse
    always_ff @(posedge clk) begin
        if (!rst_n)
            restored <= 1'b0;
        else
            restored <= restore;
    end

    // R8: a restore leaves the default in place
    p_restore_default_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> (lock_q == DEFAULT) && restored);

    // R9: a load takes the written bits
    p_load_takes_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !restore) |=> lock_q == $past(data));

    // R9: without load or restore the bits hold
    p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !restore) |=> $stable(lock_q) && !restored);

endmodule

// File: rtl/rwg_write_policy.sv
// Module rwg_write_policy
// Combinational allow decision for one write: classifies the address and
// applies the lock bit, program mode or window state that governs it.
// Assumes the state inputs are the registered values before this write.
module rwg_write_policy
    import rwg_pkg::*;
(
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [2:0]    locks,
    input  logic          prog_mode,
    input  logic          ctrl_open,
    input  logic          mem_open,
    output logic          allow,
    output rwg_region_e   region
);
    logic grant;

    // Classify the address
    always_comb begin
        region = classify(addr);
    end

    // Pick the condition that governs this region
    always_comb begin
        unique case (region)
            RG_BRT:   grant = !locks[LK_BRT];
            RG_CUR:   grant = !locks[LK_CUR];
            RG_CFG:   grant = !locks[LK_CFG];
            RG_PROG:  grant = prog_mode;
            RG_FREE:  grant = 1'b1;
            RG_CTRL:  grant = ctrl_open;
            RG_CGATE: grant = 1'b1;
            RG_MEM:   grant = mem_open;
            RG_MGATE: grant = 1'b1;
            default:  grant = 1'b0;
        endcase
        allow = wr_en && grant;
    end

    // R4: the program-only range never opens outside program mode
    always_comb begin
        if (wr_en && region == RG_PROG && !prog_mode)
            a_prog_only_r4: assert (!allow);
    end

endmodule

// File: rtl/reg_write_gate.sv
// Module reg_write_gate
// Top of the write-protection gate. Produces a same-cycle write allow from
// the lock bits, program mode and two code-gated windows, and keeps the
// lock register and both sequencers. Synchronous active-low reset.
module reg_write_gate
    import rwg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              prog_mode,
    output logic              wr_allow,
    output logic              ctrl_open,
    output logic              mem_open,
    output logic [3:0]        lock_state,
    output logic              lock_reset_pulse
);
    rwg_region_e region;
    logic        cgate_hit;
    logic        mgate_hit;
    logic        lock_load;

    // Decode gate hits and lock loads from the strobe
    always_comb begin
        cgate_hit = wr_en && (wr_addr == ADDR_CGATE);
        mgate_hit = wr_en && (wr_addr == ADDR_MGATE);
        lock_load = wr_allow && (wr_addr == ADDR_LOCK);
    end

    rwg_write_policy u_policy (
        .wr_en     (wr_en),
        .addr      (wr_addr),
        .locks     (lock_state[2:0]),
        .prog_mode (prog_mode),
        .ctrl_open (ctrl_open),
        .mem_open  (mem_open),
        .allow     (wr_allow),
        .region    (region)
    );

    rwg_gate_seq #(
        .CODE_LEN (CTRL_LEN),
        .BYTE_W   (DW),
        .CODE     (CTRL_CODE)
    ) u_ctrl_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (cgate_hit),
        .data  (wr_data),
        .open  (ctrl_open)
    );

    rwg_gate_seq #(
        .CODE_LEN (MEM_LEN),
        .BYTE_W   (DW),
        .CODE     (MEM_CODE)
    ) u_mem_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (mgate_hit),
        .data  (wr_data),
        .open  (mem_open)
    );

    rwg_lock_reg #(
        .WIDTH   (LOCK_W),
        .DEFAULT (LOCK_DEFAULT)
    ) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (lock_load),
        .restore  (cgate_hit),
        .data     (wr_data[LOCK_W-1:0]),
        .lock_q   (lock_state),
        .restored (lock_reset_pulse)
    );

    // R5: no write is ever allowed without a strobe
    p_allow_needs_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_allow |-> wr_en);

    // R6: the control range follows the control window
    p_ctrl_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && region == RG_CTRL) |-> (wr_allow == ctrl_open));

    // R10: the memory-control register follows its window
    p_mem_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && region == RG_MEM) |-> (wr_allow == mem_open));

    // R8: a restore pulse always shows the default lock bits
    p_pulse_default_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lock_reset_pulse |-> (lock_state == LOCK_DEFAULT));

    // R12: the first cycle after reset is in the reset state
    p_reset_state_r12: assert property (@(posedge clk)
        !rst_n |=> (lock_state == LOCK_DEFAULT) && !ctrl_open && !mem_open && !lock_reset_pulse);

endmodule

// File: tb/sim_reg_write_gate.sv
module sim_reg_write_gate;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic       prog_mode = 1'b0;
    logic       wr_allow;
    logic       ctrl_open;
    logic       mem_open;
    logic [3:0] lock_state;
    logic       lock_reset_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    logic [3:0] m_lock;
    bit         m_copen, m_mopen;
    int         m_cidx, m_midx;
    logic [7:0] c_code [4] = '{8'h43, 8'h4F, 8'h44, 8'h45};
    logic [7:0] m_code [6] = '{8'h00, 8'h04, 8'h02, 8'h09, 8'h02, 8'h09};

    always #10 clk = ~clk;

    reg_write_gate u0 (
        .clk              (clk),
        .rst_n            (rst_n),
        .wr_en            (wr_en),
        .wr_addr          (wr_addr),
        .wr_data          (wr_data),
        .prog_mode        (prog_mode),
        .wr_allow         (wr_allow),
        .ctrl_open        (ctrl_open),
        .mem_open         (mem_open),
        .lock_state       (lock_state),
        .lock_reset_pulse (lock_reset_pulse)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [7:0] a);
        if (a <= 8'h17 || (a >= 8'h20 && a <= 8'h37) || (a >= 8'h40 && a <= 8'h44)) return "R1";
        if (a >= 8'h50 && a <= 8'h67) return "R2";
        if (a >= 8'h70 && a <= 8'h83) return "R3";
        if (a >= 8'h84 && a <= 8'h87) return "R4";
        if (a >= 8'h92 && a <= 8'h95) return "R6";
        if (a == 8'h97) return "R10";
        return "R5";
    endfunction

    function automatic bit exp_allow(input logic [7:0] a);
        if (a <= 8'h17 || (a >= 8'h20 && a <= 8'h37) || (a >= 8'h40 && a <= 8'h44)) return !m_lock[0];
        if (a >= 8'h50 && a <= 8'h67) return !m_lock[1];
        if (a >= 8'h70 && a <= 8'h83) return !m_lock[2];
        if (a >= 8'h84 && a <= 8'h87) return prog_mode;
        if (a == 8'h90 || a == 8'h91 || a == 8'h96 || a == 8'h98) return 1'b1;
        if (a >= 8'h92 && a <= 8'h95) return m_copen;
        if (a == 8'h97) return m_mopen;
        return 1'b0;
    endfunction

    task automatic model_reset();
        m_lock = 4'b0110; m_copen = 0; m_mopen = 0; m_cidx = 0; m_midx = 0;
    endtask

    task automatic model_write(input logic [7:0] a, input logic [7:0] d);
        if (a == 8'h93 && m_copen) m_lock = d[3:0];
        if (a == 8'h96) begin
            m_lock = 4'b0110;
            if (m_copen) begin m_copen = 0; m_cidx = 0; end
            else if (d == c_code[m_cidx]) begin
                if (m_cidx == 3) begin m_copen = 1; m_cidx = 0; end else m_cidx++;
            end else m_cidx = (d == c_code[0]) ? 1 : 0;
        end
        if (a == 8'h98) begin
            if (m_mopen) begin m_mopen = 0; m_midx = 0; end
            else if (d == m_code[m_midx]) begin
                if (m_midx == 5) begin m_mopen = 1; m_midx = 0; end else m_midx++;
            end else m_midx = (d == m_code[0]) ? 1 : 0;
        end
    endtask

    task automatic check_state(input string tag);
        check("R9", {4'h0, lock_state}, {4'h0, m_lock}, {tag, " lock_state"});
        check("R6", {7'h0, ctrl_open}, {7'h0, m_copen}, {tag, " ctrl_open"});
        check("R10", {7'h0, mem_open}, {7'h0, m_mopen}, {tag, " mem_open"});
    endtask

    // one write: allow checked in the strobe cycle, state one cycle later
    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        check("R8", {7'h0, lock_reset_pulse}, 8'h0, "pulse idle");
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        #1;
        check(req_of(a), {7'h0, wr_allow}, {7'h0, exp_allow(a)}, $sformatf("allow @%0h", a));
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
        #1;
        check("R8", {7'h0, lock_reset_pulse}, {7'h0, (a == 8'h96)}, "pulse after write");
        check_state($sformatf("after %0h<=%0h", a, d));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        #1;
        check("R12", {4'h0, lock_state}, 8'h06, "reset lock");
        check("R12", {6'h0, ctrl_open, mem_open}, 8'h0, "reset windows");
        check("R12", {7'h0, lock_reset_pulse}, 8'h0, "reset pulse");
    endtask

    task automatic sweep(input logic [7:0] d);
        for (int a = 0; a < 256; a++) do_write(8'(a), d);
    endtask

    task automatic open_ctrl();
        do_write(8'h96, 8'h43); do_write(8'h96, 8'h4F);
        do_write(8'h96, 8'h44); do_write(8'h96, 8'h45);
    endtask

    initial begin
        model_reset();
        do_reset();
        // R5: no strobe, no allow
        @(negedge clk);
        wr_addr = 8'h90; #1;
        check("R5", {7'h0, wr_allow}, 8'h0, "allow without strobe");
        // default sweeps, program mode off then on (R1-R5 ranges)
        sweep(8'h00);
        prog_mode = 1'b1;
        sweep(8'h5A);
        prog_mode = 1'b0;
        // R6: open control window, load inverted locks
        open_ctrl();
        check("R6", {7'h0, ctrl_open}, 8'h1, "open after code");
        do_write(8'h93, 8'h09);
        check("R9", {4'h0, lock_state}, 8'h09, "lock loaded");
        do_write(8'h93, 8'h08); // R9: all groups unlocked, spare bit set
        sweep(8'h00);           // passes 93h (locks to 0) and 96h (close, R7/R8)
        check("R7", {7'h0, ctrl_open}, 8'h0, "closed by sweep");
        // R9: locks closed, 93h ignored
        do_write(8'h93, 8'h00);
        check("R9", {4'h0, lock_state}, 8'h06, "lock ignored when closed");
        // R11: stray first byte mid-code counts as step one
        do_write(8'h96, 8'h43); do_write(8'h96, 8'h4F);
        do_write(8'h96, 8'h43); do_write(8'h96, 8'h4F);
        do_write(8'h96, 8'h44); do_write(8'h96, 8'h45);
        check("R11", {7'h0, ctrl_open}, 8'h1, "restart on first byte");
        do_write(8'h96, 8'h43); // R7: closes, not step one
        do_write(8'h96, 8'h4F); do_write(8'h96, 8'h44); do_write(8'h96, 8'h45);
        check("R7", {7'h0, ctrl_open}, 8'h0, "closing byte not counted");
        // R11: wrong byte restarts
        do_write(8'h96, 8'h43); do_write(8'h96, 8'h11);
        do_write(8'h96, 8'h4F); do_write(8'h96, 8'h44); do_write(8'h96, 8'h45);
        check("R11", {7'h0, ctrl_open}, 8'h0, "mismatch restart");
        // R10: memory code with break after five bytes on 00h
        do_write(8'h98, 8'h00); do_write(8'h98, 8'h04); do_write(8'h98, 8'h02);
        do_write(8'h98, 8'h09); do_write(8'h98, 8'h02); do_write(8'h98, 8'h00);
        do_write(8'h98, 8'h04); do_write(8'h98, 8'h02); do_write(8'h98, 8'h09);
        do_write(8'h98, 8'h02); do_write(8'h98, 8'h09);
        check("R10", {7'h0, mem_open}, 8'h1, "mem window open");
        do_write(8'h97, 8'hAA);
        open_ctrl();
        do_write(8'h93, 8'h00);
        prog_mode = 1'b1;
        sweep(8'h01);           // both windows open at start, 93h loads 1
        prog_mode = 1'b0;
        check("R10", {7'h0, mem_open}, 8'h0, "mem closed by sweep");
        // R12: reset discards partial progress
        do_write(8'h96, 8'h43); do_write(8'h96, 8'h4F); do_write(8'h96, 8'h44);
        do_reset();
        do_write(8'h96, 8'h45);
        check("R12", {7'h0, ctrl_open}, 8'h0, "progress cleared");
        open_ctrl();
        do_write(8'h98, 8'h00);
        do_reset();
        sweep(8'h00);
        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (100000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule